// File: doc/BRIEF.md
# Sequential Booth Multiplier (radix-2, signed)

This block multiplies two signed two's-complement integers of `WIDTH` bits and returns a signed product of `2*WIDTH` bits. It takes several cycles and handles one bit of the multiplier per cycle. In each cycle it looks at two adjacent bits of the multiplier: the current low bit and the bit that was shifted out just before it. From that pair it decides whether to add the multiplicand into a running partial product, subtract it, or leave the partial product alone. It then shifts the whole partial-product chain right by one place, keeping the sign. A run of ones in the multiplier therefore costs only one subtraction where the run begins and one addition where it ends. Negative operands need no separate sign fix-up.

A caller places both operands on the inputs and raises `start` for one cycle while the unit is idle. After `WIDTH` iterations the unit loads the product into a registered output and pulses `done` for one cycle. The product output keeps its value until the next multiplication completes. A `start` that arrives while a multiplication is in progress is ignored.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst` is high at a rising edge, and after that edge, `product` is 0 and `done` is 0.
- R2: The unit accepts a `start` sampled high at a rising edge while it is idle. It captures `mcand` and `mplier` at that edge. `done` rises exactly `WIDTH` rising edges later. Operand changes after the capturing edge have no effect on the result.
- R3: `done` is high for exactly one cycle per accepted start and is never high in two consecutive cycles.
- R4: When `done` is high, `product` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value. This holds for every combination of operand signs.
- R5: The most negative operand value, -2^(WIDTH-1), gives the correct product as multiplicand, as multiplier, and as both. A subtraction of that multiplicand must not corrupt the sign of the partial product.
- R6: A `start` sampled while a multiplication is in progress is ignored. It does not change the pending result, does not restart the count, and adds no `done` pulse.
- R7: `product` changes only at the edge where `done` rises. In every cycle where `done` is low, it holds its previous value.
- R8: With `WIDTH`=8, 7 times 3 gives 21 (0x0015), and 23 times -9 gives -207 (0xFF31).
- R9: If `start` is held high continuously, the unit accepts a new multiplication at the first edge after `done` goes high, so back-to-back jobs are spaced `WIDTH`+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a multiplication when the unit is idle |
| mcand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| mplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| product | output | 2*WIDTH | Registered signed product, updated when `done` rises |
| done | output | 1 | One-cycle pulse marking a new valid product |

## Verification
The assertions rely on `start` and the operands having defined values at every sampled edge after reset. They also rely on reset being held for at least one edge before the first operation, because the operand latch in the checker and the sequence counter start from their reset values. The stimulus drives every input on the falling clock edge and holds reset for several cycles first. It runs single jobs, `start` pulses in the middle of a job, and long stretches with `start` held high, so the operands and the accept window are always well defined at the edges the properties sample.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Action selected by the current/previous multiplier bit pair
  typedef enum logic [1:0] {
    BOP_HOLD = 2'd0,
    BOP_ADD  = 2'd1,
    BOP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  // Pair {cur,prev}: 10 starts a run of ones (subtract), 01 ends one (add)
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = BOP_SUB;
      2'b01:   op = BOP_ADD;
      default: op = BOP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   acc,
  input  logic [WIDTH-1:0] mc,
  input  booth_op_e        op,
  output logic [WIDTH:0]   sum
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] mc_ext;
  logic [EXT_W-1:0] operand;
  logic             carry_in;

  // One guard bit keeps the sign right when the most negative value is subtracted
  assign mc_ext = {mc[WIDTH-1], mc};

  always_comb begin
    operand  = '0;
    carry_in = 1'b0;
    unique case (op)
      BOP_ADD: operand = mc_ext;
      BOP_SUB: begin
        operand  = ~mc_ext;
        carry_in = 1'b1;
      end
      default: operand = '0;
    endcase
    sum = acc + operand + {{(EXT_W-1){1'b0}}, carry_in};
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_comb begin
    load = start && !busy_q;
    step = busy_q;
    last = busy_q && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(WIDTH);
      end else if (step) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;
  assign done = done_q;
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [WIDTH-1:0]     mcand,
  input  logic [WIDTH-1:0]     mplier,
  output logic [2*WIDTH-1:0]   product,
  output logic                 done
);
  localparam int CNT_W  = $clog2(WIDTH + 1);
  localparam int PROD_W = 2 * WIDTH;

  logic             load, step, last, busy_q;
  logic [CNT_W-1:0] cnt_q;

  logic [WIDTH:0]     acc_q;    // partial product with guard bit
  logic [WIDTH-1:0]   mq_q;     // multiplier, becomes low product half
  logic               prev_q;   // bit shifted out last
  logic [WIDTH-1:0]   mc_q;     // captured multiplicand
  logic [PROD_W-1:0]  prod_q;

  booth_op_e        op;
  logic [WIDTH:0]   sum;
  logic [WIDTH:0]   acc_nxt;
  logic [WIDTH-1:0] mq_nxt;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy_q),
    .cnt   (cnt_q),
    .done  (done)
  );

  booth_recode u_recode (
    .cur_bit  (mq_q[0]),
    .prev_bit (prev_q),
    .op       (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc (acc_q),
    .mc  (mc_q),
    .op  (op),
    .sum (sum)
  );

  // Arithmetic right shift of {sum, mq, prev} by one place
  always_comb begin
    acc_nxt = {sum[WIDTH], sum[WIDTH:1]};
    mq_nxt  = {sum[0], mq_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      mq_q   <= '0;
      prev_q <= 1'b0;
      mc_q   <= '0;
      prod_q <= '0;
    end else if (load) begin
      acc_q  <= '0;
      mq_q   <= mplier;
      prev_q <= 1'b0;
      mc_q   <= mcand;
    end else if (step) begin
      acc_q  <= acc_nxt;
      mq_q   <= mq_nxt;
      prev_q <= mq_q[0];
      if (last) prod_q <= {acc_nxt[WIDTH-1:0], mq_nxt};
    end
  end

  assign product = prod_q;
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic [WIDTH-1:0]     mcand,
  input logic [WIDTH-1:0]     mplier,
  input logic [2*WIDTH-1:0]   product,
  input logic                 done,
  input logic                 busy,
  input logic [CNT_W-1:0]     cnt
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0]     a_lat, b_lat;
  logic signed [PW-1:0] a_ext, b_ext, ref_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_lat <= '0;
      b_lat <= '0;
    end else if (start && !busy) begin
      a_lat <= mcand;
      b_lat <= mplier;
    end
  end

  assign a_ext    = {{WIDTH{a_lat[WIDTH-1]}}, a_lat};
  assign b_ext    = {{WIDTH{b_lat[WIDTH-1]}}, b_lat};
  assign ref_prod = a_ext * b_ext;

  // R1: outputs idle after a reset edge
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (product == '0 && !done));

  // R2: accepted start loads the full count
  assert_accept_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && cnt == CNT_W'(WIDTH)));

  // R2: done follows the final iteration
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy || cnt == CNT_W'(WIDTH)) && $past(busy));

  // R3: single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: value at completion
  assert_product_value_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == ref_prod));

  // R6: busy iterations continue regardless of start
  assert_busy_counts_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt > CNT_W'(1)) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));

  // R7: product holds while done is low
  assert_product_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .product (product),
  .done    (done),
  .busy    (busy_q),
  .cnt     (cnt_q)
);

// File: tb/booth_seq_mult_tb.sv
module booth_seq_mult_tb;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic [PW-1:0] product;
  logic          done;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // reference model state
  bit            m_busy = 0;
  int            m_rem = 0;
  longint        m_a = 0, m_b = 0;
  bit            m_done = 0;
  logic [PW-1:0] m_prod = '0;

  always #4 clk = ~clk;

  booth_seq_mult #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .done(done)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_rem = 0; m_done = 0; m_prod = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_busy = 0;
          m_done = 1;
          m_prod = PW'(m_a * m_b);
        end
      end else if (start) begin
        m_busy = 1;
        m_rem  = W;
        m_a    = longint'($signed(mcand));
        m_b    = longint'($signed(mplier));
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (done !== m_done) begin
      errors++;
      $display("FAIL %s (R3 done) actual=%0b expected=%0b", tag, done, m_done);
    end
    checks++;
    if (product !== m_prod) begin
      errors++;
      $display("FAIL %s (R4 product) actual=%h expected=%h", tag, product, m_prod);
    end
  end

  task automatic run_job(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = b + 8'd5;  // R2: late operand changes must not matter
    repeat (W + 1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    tag = "R8";
    run_job(8'd7, 8'd3);
    run_job(8'd23, 8'hF7);

    tag = "R4";
    run_job(8'd100, 8'd77);
    run_job(8'hCE, 8'd45);
    run_job(8'd19, 8'hA1);
    run_job(8'hF0, 8'hE3);
    run_job(8'd0, 8'h99);
    run_job(8'hFF, 8'hFF);
    run_job(8'h55, 8'hAA);
    for (int i = 0; i < 40; i++) run_job(W'($urandom), W'($urandom));

    tag = "R5";
    run_job(8'h80, 8'h80);
    run_job(8'h80, 8'd1);
    run_job(8'h80, 8'h7F);
    run_job(8'h7F, 8'h80);
    run_job(8'hFF, 8'h80);

    tag = "R6";
    @(negedge clk);
    start = 1'b1; mcand = 8'd12; mplier = 8'd11;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; mcand = 8'h81; mplier = 8'h3C;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 2) @(negedge clk);

    tag = "R9";
    start = 1'b1;
    for (int i = 0; i < 4 * (W + 1); i++) begin
      mcand = W'($urandom); mplier = W'($urandom);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (W + 2) @(negedge clk);

    tag = "R7";
    mcand = 8'h33; mplier = 8'h44;
    repeat (6) @(negedge clk);

    tag = "R1";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule